// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Resolver

The block picks which of seven interrupt sources the CPU should take next. Software sets a per-source enable mask and a global enable. It also sets two priority masks. For each source, the bit from the high mask and the bit from the low mask together form a 2-bit level from 0 to 3. Among the sources that are pending, enabled and eligible, the one with the highest level wins. When several share that level, a fixed natural order decides. The block drives a request line and the entry address of the winning source.

The block keeps a record of the levels currently being serviced, one bit per level. When the CPU accepts a request, it pulses the acknowledge strobe and the level of the winner is marked busy. When the CPU returns from a handler, it pulses the return strobe and the highest busy level is released. While any level is busy, only a source with a strictly higher level can raise a request. This allows up to four nested handlers.

A two-state controller tracks nesting. In `ST_IDLE` no level is in service. Acknowledging a request moves it to `ST_BUSY` (transition *enter*). In `ST_BUSY`, a further acknowledge stays in `ST_BUSY` (*nest*). A return that releases the last busy level goes back to `ST_IDLE` (*unwind*). A return that leaves other levels busy stays in `ST_BUSY` (*pop*). A return in `ST_IDLE` does nothing.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the enable mask, both priority masks and the in-service record are all zero, and `irq` stays low whatever `src_pend` holds.
- R2: A source can request only when global enable (bit 7 of the enable register) is 1 and its own enable bit (bit i for source i) is 1.
- R3: Register writes use `reg_sel` 0 for the enable register, 1 for the low priority mask and 2 for the high priority mask. A write with `reg_sel` 3 changes nothing. Source i takes level {high mask bit i, low mask bit i}.
- R4: Among eligible sources, the one with the highest level wins.
- R5: Among eligible sources of equal level, the lowest index wins. The index order is 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial 0, 5 timer 2, 6 serial 1.
- R6: `vector` is 03h + 8 × index of the winner (03h, 0Bh, …, 33h) while `irq` is high, and 00h while `irq` is low. `irq` and `vector` follow the inputs and register state in the same cycle.
- R7: While any level is in service, a source is eligible only if its level is strictly greater than the highest level in service.
- R8: `ack` while `irq` is high marks the winner's level as in service at the next clock edge. `ack` while `irq` is low is ignored.
- R9: `reti` clears the highest in-service level at the next edge and has no effect when nothing is in service. When `reti` and `ack` arrive together, `ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | 7 | Pending flag per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 low priority, 2 high priority |
| reg_wdata | input | 8 | Register write data |
| ack | input | 1 | CPU accepts the current request |
| reti | input | 1 | CPU returns from the current handler |
| irq | output | 1 | Interrupt request |
| vector | output | 8 | Entry address of the winning source |

## Verification
Errors in the in-service record show up at the ports within one cycle. A level left set wrongly masks sources that should request, so `irq` drops. A level cleared wrongly lets an equal or lower source raise `irq` during a handler. A wrong level or index from the selector shows as a wrong `vector` in the same cycle that the pending pattern appears. The stimulus therefore follows every nesting step and every return with a pending pattern that spans several levels, so the next compare exposes a faulty record.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int LVL_W = 2;
    localparam int N_LVL = 1 << LVL_W;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PRIO_LO = 2'd1,
        SEL_PRIO_HI = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } svc_state_e;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [1:0]                   sel,
    input  logic [7:0]                   wdata,
    output logic                         glob_en,
    output logic [N_SRC-1:0]             src_en,
    output logic [N_SRC-1:0][LVL_W-1:0]  src_lvl
);
    logic [N_SRC-1:0] prio_lo;
    logic [N_SRC-1:0] prio_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            src_en  <= '0;
            prio_lo <= '0;
            prio_hi <= '0;
        end else if (we) begin
            unique case (reg_sel_e'(sel))
                SEL_ENABLE: begin
                    glob_en <= wdata[7];
                    src_en  <= wdata[N_SRC-1:0];
                end
                SEL_PRIO_LO: prio_lo <= wdata[N_SRC-1:0];
                SEL_PRIO_HI: prio_hi <= wdata[N_SRC-1:0];
                SEL_NONE: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
        assign src_lvl[i] = {prio_hi[i], prio_lo[i]};
    end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 7,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             pend,
    input  logic [N_SRC-1:0]             src_en,
    input  logic                         glob_en,
    input  logic [N_SRC-1:0][LVL_W-1:0]  src_lvl,
    input  logic                         busy,
    input  logic [LVL_W-1:0]             cur_lvl,
    output logic                         found,
    output logic [IDX_W-1:0]             win_idx,
    output logic [LVL_W-1:0]             win_lvl
);
    logic [N_SRC-1:0] cand;

    for (genvar i = 0; i < N_SRC; i++) begin : g_cand
        assign cand[i] = pend[i] & src_en[i] & glob_en &
                         (~busy | (src_lvl[i] > cur_lvl));
    end

    // Strict compare keeps the lowest index among equal levels.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && (!found || src_lvl[i] > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_svc.sv
module irq_prio_svc
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               reti,
    input  logic [LVL_W-1:0]   win_lvl,
    output logic               busy,
    output logic [LVL_W-1:0]   cur_lvl,
    output logic [N_LVL-1:0]   mask
);
    svc_state_e state, state_nxt;
    logic       last_one;
    logic       do_take;
    logic       do_pop;

    assign last_one = (mask & (mask - N_LVL'(1))) == '0;

    always_comb begin
        cur_lvl = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (mask[l]) cur_lvl = LVL_W'(l);
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state and strobes.
    always_comb begin
        state_nxt = state;
        do_take   = 1'b0;
        do_pop    = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (take && !reti) begin
                    do_take   = 1'b1;
                    state_nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                busy = 1'b1;
                if (reti) begin
                    do_pop = 1'b1;
                    if (last_one) state_nxt = ST_IDLE;
                end else if (take) begin
                    do_take = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (do_pop)  mask[cur_lvl] <= 1'b0;
        else if (do_take) mask[win_lvl] <= 1'b1;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 7,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pend,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic             ack,
    input  logic             reti,
    output logic             irq,
    output logic [7:0]       vector
);
    logic                        glob_en;
    logic [N_SRC-1:0]            src_en;
    logic [N_SRC-1:0][LVL_W-1:0] src_lvl;
    logic                        busy;
    logic [LVL_W-1:0]            cur_lvl;
    logic [N_LVL-1:0]            svc_mask;
    logic                        found;
    logic [IDX_W-1:0]            win_idx;
    logic [LVL_W-1:0]            win_lvl;

    irq_prio_regs #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .glob_en(glob_en), .src_en(src_en), .src_lvl(src_lvl)
    );

    irq_prio_select #(.N_SRC(N_SRC)) u_sel (
        .pend(src_pend), .src_en(src_en), .glob_en(glob_en), .src_lvl(src_lvl),
        .busy(busy), .cur_lvl(cur_lvl),
        .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_prio_svc u_svc (
        .clk(clk), .rst_n(rst_n), .take(ack & found), .reti(reti),
        .win_lvl(win_lvl), .busy(busy), .cur_lvl(cur_lvl), .mask(svc_mask)
    );

    assign irq    = found;
    assign vector = found ? {{(8-3-IDX_W){1'b0}}, win_idx, 3'b011} : 8'h00;
endmodule

module irq_prio_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       reti,
    input logic       irq,
    input logic [7:0] vector,
    input logic       glob_en,
    input logic [3:0] svc_mask
);
    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !irq);
    a_r6_vector_form: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vector[2:0] == 3'b011 && vector <= 8'h33));
    a_r6_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> vector == 8'h00);
    a_r8_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !reti) |=> svc_mask != 4'h0);
    a_r7_nest_higher: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !reti && svc_mask != 4'h0) |=> svc_mask > $past(svc_mask));
    a_r9_reti_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && svc_mask != 4'h0) |=> $countones(svc_mask) + 1 == $countones($past(svc_mask)));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .irq(irq),
    .vector(vector), .glob_en(glob_en), .svc_mask(svc_mask)
);

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_pend = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_en = '0;
    logic [6:0] m_lo = '0;
    logic [6:0] m_hi = '0;
    logic [3:0] m_mask = '0;

    always #4 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ack(ack), .reti(reti),
        .irq(irq), .vector(vector)
    );

    function automatic int top_lvl(input logic [3:0] m);
        int t = -1;
        for (int l = 0; l < 4; l++) if (m[l]) t = l;
        return t;
    endfunction

    // Returns winner index or -1.
    function automatic int pick(input logic [6:0] p);
        int best = -1;
        int bl = -1;
        int cur = top_lvl(m_mask);
        for (int i = 0; i < 7; i++) begin
            int l = {m_hi[i], m_lo[i]};
            if (p[i] && m_en[i] && m_en[7] && l > cur && l > bl) begin
                best = i;
                bl = l;
            end
        end
        return best;
    endfunction

    task automatic step(input logic [6:0] p, input logic we, input logic [1:0] sel,
                        input logic [7:0] wd, input logic a, input logic r,
                        input string tag);
        int w;
        logic       e_irq;
        logic [7:0] e_vec;
        @(posedge clk);
        #1;
        src_pend = p; reg_we = we; reg_sel = sel; reg_wdata = wd; ack = a; reti = r;
        #2;
        w = pick(p);
        e_irq = (w >= 0);
        e_vec = e_irq ? 8'(8'h03 + 8 * w) : 8'h00;
        checks++;
        if (irq !== e_irq || vector !== e_vec) begin
            errors++;
            $display("FAIL %s: irq/vector got %0b/%02h expected %0b/%02h",
                     tag, irq, vector, e_irq, e_vec);
        end
        // Apply what the coming edge does.
        if (r) begin
            int t = top_lvl(m_mask);
            if (t >= 0) m_mask[t] = 1'b0;
        end else if (a && w >= 0) begin
            m_mask[{m_hi[w], m_lo[w]}] = 1'b1;
        end
        if (we) begin
            case (sel)
                2'd0: m_en = wd;
                2'd1: m_lo = wd[6:0];
                2'd2: m_hi = wd[6:0];
                default: ;
            endcase
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, everything pending, nothing may request
        step(7'h7F, 0, 0, 0, 0, 0, "R1");
        step(7'h7F, 0, 0, 0, 1, 0, "R1");
        // R2: per-source enables without global enable
        step(7'h7F, 1, 0, 8'h7F, 0, 0, "R2");
        step(7'h7F, 1, 0, 8'hFF, 0, 0, "R2");
        // R5/R6: all level 0, external 0 wins at 03h
        step(7'h7F, 1, 0, 8'hFE, 0, 0, "R5");
        // R2: source 0 disabled, timer 0 wins
        step(7'h7F, 0, 0, 0, 0, 0, "R2");
        // R3: write with select 3 is ignored
        step(7'h7F, 1, 3, 8'h00, 0, 0, "R3");
        step(7'h7F, 1, 1, 8'h40, 0, 0, "R3");
        // R4/R6: serial 1 at level 1 wins, 33h
        step(7'h7F, 1, 2, 8'h20, 0, 0, "R4");
        // R3: timer 2 at level 2
        step(7'h7F, 1, 1, 8'h48, 0, 0, "R3");
        step(7'h7F, 1, 2, 8'h28, 0, 0, "R4");
        // R4: timer 1 at level 3 wins, 1Bh; ack it
        step(7'h7F, 0, 0, 0, 1, 0, "R8");
        // R7: level 3 busy, nothing may preempt
        step(7'h7F, 0, 0, 0, 0, 0, "R7");
        // R8: ack with no request ignored
        step(7'h7F, 0, 0, 0, 1, 0, "R8");
        // R9: return, level 3 released
        step(7'h7F, 0, 0, 0, 0, 1, "R9");
        step(7'h20, 0, 0, 0, 1, 0, "R7");
        // R7: level 2 busy, level 1 and equal level blocked
        step(7'h60, 0, 0, 0, 0, 0, "R7");
        step(7'h08, 0, 0, 0, 1, 1, "R9");
        step(7'h7F, 0, 0, 0, 0, 1, "R9");
        step(7'h7F, 0, 0, 0, 0, 1, "R9");
        // R5: equal levels, lowest index among 4,5
        step(7'h00, 1, 2, 8'h00, 0, 0, "R5");
        step(7'h00, 1, 1, 8'h00, 0, 0, "R5");
        step(7'h30, 0, 0, 0, 0, 0, "R5");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [6:0] p = 7'($urandom);
            logic we = ($urandom % 6) == 0;
            logic [1:0] sel = 2'($urandom);
            logic [7:0] wd = 8'($urandom) | 8'h80;
            logic a = ($urandom % 3) == 0;
            logic r = ($urandom % 5) == 0;
            step(p, we, sel, wd, a, r, "R4");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule